// File: doc/BRIEF.md
# Machine-Check Error Reporting Bank

This block is one error-reporting bank of a processor's machine-check logic. It holds a control register, which enables error sources, and a status register, into which hardware error sources log a single error record. The record carries a valid flag, an overflow flag, an uncorrected flag, an error code, a model-specific code and a generic information field. Software reads and writes both registers through a 64-bit register port. A write that breaks the access rules raises a one-cycle fault strobe and is discarded.

Three static capability inputs choose how the upper part of the status word is presented. The first shows a saturating count of corrected errors in place of part of the information field. The second shows a two-bit threshold indication. The third is a layout-extension bit; when it is set, the threshold view is withdrawn. The block contains only the register storage, the logging rules and the read layout. Error detection and exception delivery sit outside it.

Top module: `mc_err_bank`

## Requirements
- R1: After reset, both registers read as zero and `gp_fault` is low.
- R2: An accepted log into a status word whose valid bit (63) is clear sets bit 63, clears bit 62, sets bit 61 to the inverse of `log_corr`, and captures `log_code` in bits 15:0, `log_model` in bits 31:16 and `log_other[5:0]` in bits 37:32. Bits 60:57 read as zero.
- R3: A control write (`reg_addr`=0) is accepted only when the value is all zeros or all ones. Any other value leaves the register unchanged and drives `gp_fault` high for exactly the cycle after the write.
- R4: A status write (`reg_addr`=1) of zero clears the whole status word, including the corrected count. A nonzero status write leaves the word unchanged and drives `gp_fault` high for the cycle after the write.
- R5: With `cap_corr_cnt`=1, bits 52:38 show the number of accepted logs with `log_corr`=1 since the last clear. With `cap_corr_cnt`=0, bits 52:38 show `log_other[20:6]` of the captured record.
- R6: With `cap_thresh`=1 and `cap_ext_layout`=0, bits 56:55 read zero. In that case bits 54:53 read 2'b10 when `cap_corr_cnt`=1, `thr_limit` is nonzero and the count is at least `thr_limit`; otherwise they read 2'b00. In every other capability setting, bits 56:53 show `log_other[24:21]`.
- R7: An accepted log while bit 63 is set sets overflow bit 62 and keeps bits 61 and 37:0 and the information field. A corrected log still increments the count.
- R8: A log from source `log_src` is accepted only when control bit `log_src` is set. Otherwise the status word is unchanged.
- R9: The corrected count saturates at 32767 and never wraps.
- R10: When an accepted log and a zero status write fall in the same cycle, the log is applied to the uncleared word and the write has no effect.
- R11: `reg_rdata` shows the control register while `reg_addr`=0 and the status word while `reg_addr`=1, in the same cycle, reflecting every edge up to the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_corr_cnt | input | 1 | Capability: show corrected count in bits 52:38 |
| cap_thresh | input | 1 | Capability: show threshold status in bits 54:53 |
| cap_ext_layout | input | 1 | Capability: extended layout, withdraws the threshold view |
| thr_limit | input | 15 | Count at which the threshold indication turns to 2'b10 |
| log_req | input | 1 | Hardware log request |
| log_src | input | SRC_W | Index of the logging source |
| log_corr | input | 1 | The logged error was corrected |
| log_code | input | 16 | Error code |
| log_model | input | 16 | Model-specific code |
| log_other | input | 25 | Generic information for bits 56:32 |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |
| gp_fault | output | 1 | One-cycle strobe after an illegal write |

## Verification
The assertions assume that the capability inputs and `thr_limit` change only while no log is in flight, and that `log_src` points at an existing source. The stimulus keeps to this. It changes the capability inputs only during idle read cycles and uses source indices below the source count. Each log request and write is held for exactly one clock, so the fault-strobe and stability properties always see a single event per cycle. The same-cycle collision of a log with a clear is driven on purpose, because the priority rule depends on it.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
   localparam int REG_W    = 64;
   localparam int CODE_W   = 16;
   localparam int OTHER_W  = 25;
   localparam int CNT_W    = 15;
   localparam int VAL_B    = 63;
   localparam int OVF_B    = 62;
   localparam int UC_B     = 61;
   localparam int MODEL_LO = 16;
   localparam int OTH_LO   = 32;
   localparam int CNT_LO   = 38;
   localparam int THR_LO   = 53;
   localparam int RSV_LO   = 55;
   localparam logic [1:0] THR_GREEN  = 2'b00;
   localparam logic [1:0] THR_YELLOW = 2'b10;

   typedef struct packed {
      logic                valid;
      logic                ovf;
      logic                uc;
      logic [CODE_W-1:0]   code;
      logic [CODE_W-1:0]   model;
      logic [OTHER_W-1:0]  other;
      logic [CNT_W-1:0]    cnt;
   } bank_t;
endpackage

// File: rtl/mcb_ctl_reg.sv
module mcb_ctl_reg #(
   parameter int W       = 64,
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [W-1:0]       wr_data,
   output logic [W-1:0]       ctl_q,
   output logic [NUM_SRC-1:0] src_en,
   output logic               wr_bad
);
   logic all_zero, all_one;

   initial begin
      assert (NUM_SRC >= 1 && NUM_SRC <= W)
         else $error("mcb_ctl_reg: NUM_SRC out of range");
   end

   assign all_zero = (wr_data == '0);
   assign all_one  = (wr_data == '1);
   assign wr_bad   = wr_en && !(all_zero || all_one);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (wr_en && (all_zero || all_one))
         ctl_q <= wr_data;
   end

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
         assign src_en[i] = ctl_q[i];
      end
   endgenerate

   // R3
   ctl_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_bad |=> $stable(ctl_q));

   // R3
   ctl_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q == '0) || (ctl_q == '1));
endmodule

// File: rtl/mcb_status_core.sv
module mcb_status_core
   import mcb_pkg::*;
#(
   parameter int NUM_SRC      = 4,
   parameter int SRC_W        = 2,
   parameter bit CNT_SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                log_req,
   input  logic [SRC_W-1:0]    log_src,
   input  logic                log_corr,
   input  logic [CODE_W-1:0]   log_code,
   input  logic [CODE_W-1:0]   log_model,
   input  logic [OTHER_W-1:0]  log_other,
   input  logic [NUM_SRC-1:0]  src_en,
   input  logic                sw_wr,
   input  logic [REG_W-1:0]    sw_wdata,
   output bank_t               state_q,
   output logic                sw_bad
);
   localparam int EXT_N = 1 << SRC_W;

   logic [EXT_N-1:0] en_ext;
   logic             log_take, sw_zero;
   logic [CNT_W-1:0] cnt_inc;
   bank_t            nxt;

   initial begin
      assert (EXT_N >= NUM_SRC)
         else $error("mcb_status_core: SRC_W too narrow for NUM_SRC");
   end

   assign en_ext   = EXT_N'(src_en);
   assign log_take = log_req && en_ext[log_src];
   assign sw_zero  = sw_wr && (sw_wdata == '0);
   assign sw_bad   = sw_wr && (sw_wdata != '0);

   generate
      if (CNT_SATURATE) begin : g_sat
         assign cnt_inc = (&state_q.cnt) ? state_q.cnt : state_q.cnt + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = state_q.cnt + 1'b1;
      end
   endgenerate

   always_comb begin
      nxt = state_q;
      if (log_take) begin
         if (!state_q.valid) begin
            nxt.valid = 1'b1;
            nxt.ovf   = 1'b0;
            nxt.uc    = !log_corr;
            nxt.code  = log_code;
            nxt.model = log_model;
            nxt.other = log_other;
         end else begin
            nxt.ovf = 1'b1;
         end
         if (log_corr)
            nxt.cnt = cnt_inc;
      end else if (sw_zero) begin
         nxt = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= '0;
      else
         state_q <= nxt;
   end

   // R2
   first_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
      log_take && !state_q.valid |=> state_q.valid && !state_q.ovf);

   // R7
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      log_take && state_q.valid |=> state_q.ovf && $stable(state_q.code) && $stable(state_q.other));

   // R4
   clr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_bad && !log_req |=> $stable(state_q));

   // R8
   gated_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
      log_req && !en_ext[log_src] && !sw_wr |=> $stable(state_q));

   // R9
   no_cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_zero && !log_take) |=> state_q.cnt >= $past(state_q.cnt));
endmodule

// File: rtl/mcb_status_view.sv
module mcb_status_view
   import mcb_pkg::*;
(
   input  bank_t             state,
   input  logic              cap_corr_cnt,
   input  logic              cap_thresh,
   input  logic              cap_ext_layout,
   input  logic [CNT_W-1:0]  thr_limit,
   output logic [REG_W-1:0]  word
);
   logic thr_view, yellow;

   assign thr_view = cap_thresh && !cap_ext_layout;
   assign yellow   = cap_corr_cnt && (thr_limit != '0) && (state.cnt >= thr_limit);

   always_comb begin
      word = '0;
      word[VAL_B] = state.valid;
      word[OVF_B] = state.ovf;
      word[UC_B]  = state.uc;
      word[CODE_W-1:0]              = state.code;
      word[MODEL_LO +: CODE_W]      = state.model;
      word[OTH_LO +: 6]             = state.other[5:0];
      if (cap_corr_cnt)
         word[CNT_LO +: CNT_W] = state.cnt;
      else
         word[CNT_LO +: CNT_W] = state.other[20:6];
      if (thr_view) begin
         word[RSV_LO +: 2] = 2'b00;
         word[THR_LO +: 2] = yellow ? THR_YELLOW : THR_GREEN;
      end else begin
         word[THR_LO +: 4] = state.other[24:21];
      end
   end
endmodule

// File: rtl/mc_err_bank.sv
module mc_err_bank
   import mcb_pkg::*;
#(
   parameter int NUM_SRC      = 4,
   parameter bit CNT_SATURATE = 1'b1,
   localparam int SRC_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_corr_cnt,
   input  logic               cap_thresh,
   input  logic               cap_ext_layout,
   input  logic [14:0]        thr_limit,
   input  logic               log_req,
   input  logic [SRC_W-1:0]   log_src,
   input  logic               log_corr,
   input  logic [15:0]        log_code,
   input  logic [15:0]        log_model,
   input  logic [24:0]        log_other,
   input  logic               reg_addr,
   input  logic               reg_we,
   input  logic [63:0]        reg_wdata,
   output logic [63:0]        reg_rdata,
   output logic               gp_fault
);
   logic [REG_W-1:0]   ctl_q, status_word;
   logic [NUM_SRC-1:0] src_en;
   logic               ctl_bad, st_bad;
   bank_t              state;

   initial begin
      assert (REG_W == 64 && CNT_W == 15)
         else $error("mc_err_bank: status layout expects a 64-bit word");
   end

   mcb_ctl_reg #(.W(REG_W), .NUM_SRC(NUM_SRC)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we && !reg_addr),
      .wr_data (reg_wdata),
      .ctl_q   (ctl_q),
      .src_en  (src_en),
      .wr_bad  (ctl_bad)
   );

   mcb_status_core #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .CNT_SATURATE(CNT_SATURATE)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .log_req   (log_req),
      .log_src   (log_src),
      .log_corr  (log_corr),
      .log_code  (log_code),
      .log_model (log_model),
      .log_other (log_other),
      .src_en    (src_en),
      .sw_wr     (reg_we && reg_addr),
      .sw_wdata  (reg_wdata),
      .state_q   (state),
      .sw_bad    (st_bad)
   );

   mcb_status_view u_view (
      .state          (state),
      .cap_corr_cnt   (cap_corr_cnt),
      .cap_thresh     (cap_thresh),
      .cap_ext_layout (cap_ext_layout),
      .thr_limit      (thr_limit),
      .word           (status_word)
   );

   assign reg_rdata = reg_addr ? status_word : ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         gp_fault <= 1'b0;
      else
         gp_fault <= ctl_bad || st_bad;
   end

   // R3
   fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |-> $past(reg_we));

   // R6
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr && cap_thresh && !cap_ext_layout |-> reg_rdata[56:55] == 2'b00);
endmodule

// File: tb/mc_err_bank_test.sv
`timescale 1ns/1ps
module mc_err_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_corr_cnt = 0, cap_thresh = 0, cap_ext_layout = 0;
   logic [14:0] thr_limit = '0;
   logic        log_req = 0;
   logic [1:0]  log_src = '0;
   logic        log_corr = 0;
   logic [15:0] log_code = '0, log_model = '0;
   logic [24:0] log_other = '0;
   logic        reg_addr = 0, reg_we = 0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        gp_fault;

   int vectors = 0, miscompares = 0;
   bit done = 0;

   // behavioural reference state
   logic [63:0] m_ctl = '0;
   bit          m_val = 0, m_ovf = 0, m_uc = 0, m_fault = 0;
   logic [15:0] m_code = '0, m_model = '0;
   logic [24:0] m_other = '0;
   int          m_cnt = 0;

   always #5 clk = ~clk;

   mc_err_bank uut (
      .clk(clk), .rst_n(rst_n),
      .cap_corr_cnt(cap_corr_cnt), .cap_thresh(cap_thresh), .cap_ext_layout(cap_ext_layout),
      .thr_limit(thr_limit),
      .log_req(log_req), .log_src(log_src), .log_corr(log_corr),
      .log_code(log_code), .log_model(log_model), .log_other(log_other),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .gp_fault(gp_fault)
   );

   function automatic logic [63:0] exp_status();
      logic [63:0] s = '0;
      s[63] = m_val; s[62] = m_ovf; s[61] = m_uc;
      s[15:0] = m_code; s[31:16] = m_model; s[37:32] = m_other[5:0];
      s[52:38] = cap_corr_cnt ? 15'(m_cnt) : m_other[20:6];
      if (cap_thresh && !cap_ext_layout) begin
         s[56:55] = 2'b00;
         s[54:53] = (cap_corr_cnt && thr_limit != 0 && m_cnt >= int'(thr_limit)) ? 2'b10 : 2'b00;
      end else begin
         s[56:53] = m_other[24:21];
      end
      return s;
   endfunction

   task automatic model_edge();
      bit take, clr;
      m_fault = reg_we && ((!reg_addr && reg_wdata != '0 && reg_wdata != '1) ||
                           (reg_addr && reg_wdata != '0));
      take = log_req && m_ctl[log_src];
      clr  = reg_we && reg_addr && reg_wdata == '0;
      if (take) begin
         if (!m_val) begin
            m_val = 1; m_ovf = 0; m_uc = !log_corr;
            m_code = log_code; m_model = log_model; m_other = log_other;
         end else m_ovf = 1;
         if (log_corr && m_cnt < 32767) m_cnt++;
      end else if (clr) begin
         m_val = 0; m_ovf = 0; m_uc = 0; m_code = '0; m_model = '0; m_other = '0; m_cnt = 0;
      end
      if (reg_we && !reg_addr && (reg_wdata == '0 || reg_wdata == '1)) m_ctl = reg_wdata;
   endtask

   task automatic compare(input string tag);
      logic [63:0] e = reg_addr ? exp_status() : m_ctl;
      vectors++;
      if (reg_rdata !== e || gp_fault !== m_fault) begin
         miscompares++;
         $display("FAIL %s: rdata=%h fault=%b expected rdata=%h fault=%b",
                  tag, reg_rdata, gp_fault, e, m_fault);
      end
   endtask

   // one clock: inputs were set at the previous falling edge
   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
      reg_we = 0; log_req = 0;
   endtask

   task automatic wr(input logic a, input logic [63:0] d, input string tag);
      reg_addr = a; reg_we = 1; reg_wdata = d; step(tag);
   endtask

   task automatic lg(input logic [1:0] s, input logic c, input logic [15:0] cd,
                     input logic [15:0] md, input logic [24:0] ot, input string tag);
      log_req = 1; log_src = s; log_corr = c; log_code = cd; log_model = md; log_other = ot;
      step(tag);
   endtask

   task automatic peek(input logic a, input string tag);
      reg_addr = a; step(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      peek(0, "R1 control after reset");
      peek(1, "R1 status after reset");
      // R8: sources disabled, log ignored
      reg_addr = 1;
      lg(2, 0, 16'h0BAD, 16'h0001, 25'h0000123, "R8 disabled source");
      // R3 control write rules
      wr(0, 64'h0000_0000_0000_1234, "R3 illegal control value");
      peek(0, "R3 fault strobe one cycle");
      wr(0, '1, "R3 all-ones control");
      wr(0, 64'hFFFF_FFFF_FFFF_FFFE, "R3 near-ones rejected");
      wr(0, '0, "R3 all-zeros control");
      wr(0, '1, "R3 re-enable");
      // R2 first log
      reg_addr = 1;
      lg(1, 0, 16'hA5A5, 16'h1234, 25'h1ABCDEF, "R2 first log captured");
      peek(0, "R11 control readback");
      peek(1, "R11 status readback");
      // R7 overflow
      lg(3, 1, 16'h5A5A, 16'hFFFF, 25'h0000001, "R7 overflow keeps record");
      // R4 nonzero write rejected
      wr(1, 64'h8000_0000_0000_0000, "R4 nonzero status write");
      peek(1, "R4 status unchanged");
      // capability layouts
      cap_thresh = 1; peek(1, "R6 threshold view");
      cap_corr_cnt = 1; peek(1, "R5 count view");
      cap_ext_layout = 1; peek(1, "R6 extended layout withdraws view");
      cap_ext_layout = 0; cap_corr_cnt = 0; cap_thresh = 0;
      peek(1, "R5 info field in 52:38");
      wr(1, '0, "R4 zero write clears");
      // R10 collision
      reg_we = 1; reg_addr = 1; reg_wdata = '0;
      lg(0, 0, 16'h0C0C, 16'h0D0D, 25'h0F0F0F0, "R10 log beats clear");
      wr(1, '0, "R4 clear after collision");
      // R5/R6 counting and threshold
      cap_corr_cnt = 1; cap_thresh = 1; thr_limit = 15'd3;
      for (int i = 0; i < 5; i++)
         lg(2, 1, 16'h0111, 16'h0222, 25'h1555555, "R5 R6 corrected count and threshold");
      lg(2, 0, 16'h0333, 16'h0444, 25'h0, "R5 uncorrected leaves count");
      thr_limit = 15'd0; peek(1, "R6 zero limit stays green");
      // R8 again with control cleared
      wr(0, '0, "R3 disable all");
      reg_addr = 1;
      lg(1, 1, 16'h0777, 16'h0888, 25'h0, "R8 gated count unchanged");
      wr(0, '1, "R3 enable all");
      wr(1, '0, "R4 clear before saturation");
      // R9 saturation
      thr_limit = 15'd32767;
      reg_addr = 1;
      for (int i = 0; i < 32770; i++)
         lg(0, 1, 16'h0999, 16'h0AAA, 25'h0, "R9 count saturates");
      peek(1, "R9 held at maximum");
      wr(1, '0, "R4 clear resets count");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule